// File: doc/BRIEF.md
# Cipher Engine Bus Slave

This block sits between a host processor's synchronous bus and a 64-bit block cipher engine. The host reaches it through a small register window. It can write the eight 16-bit words of a 128-bit key and stage a 64-bit plaintext block one word at a time. It reads the oldest finished ciphertext block the same way. It steers the flow with command codes written to a command register and polls a status register. An identification register gives software a scratch location it can write and read back.

Every transfer takes two clock cycles. In the address cycle the host presents an opcode, an address and a direction. In the following data cycle the block acknowledges a decoded address and then drives read data or samples write data. The block holds two FIFOs of four whole blocks each, one per direction. The engine takes plaintext blocks over a valid/ready handshake and returns ciphertext over a second handshake. A one-cycle strobe tells the engine to take up the key. The cipher itself lies outside this block.

Top module: `cipher_bus_slave`

## Requirements
- R1: A transfer starts when `bus_op` equals 2'b01 in a cycle that is not a data phase. Address and direction are captured at that edge. The next cycle is the data phase, and `bus_ack` is high in it for a decoded address. `bus_op` is ignored during a data phase, so `bus_ack` is never high for two cycles in a row.
- R2: Addresses outside the map (for example 0x00, 0x20, 0x3F) give no acknowledge. A read of one returns 0x0000, and a write to one changes nothing. The block drives `bus_data` only in the data phase of a read and leaves it at high impedance otherwise.
- R3: The ID register at 0x16 reads back the last value written and reads 0x0000 after reset.
- R4: Key words live at 0x01 to 0x08 and read back as written. They reset to zero. `eng_key` presents them with 0x01 in bits [127:112] and 0x08 in bits [15:0].
- R5: Writing 0x0001 to the command register at 0x15 raises `eng_key_load` for exactly the one cycle after the data phase.
- R6: Plaintext staging words live at 0x09 to 0x0C and read back as written, with 0x09 forming block bits [63:48]. Writing command 0x0002 queues the staged block. `eng_in_valid` is high while a block is queued. `eng_in_data` shows the oldest block and holds steady while `eng_in_ready` is low. A block leaves on a cycle with valid and ready both high.
- R7: The plaintext FIFO holds four blocks. A push into a full FIFO is dropped and sets status bit 1, which stays set until command 0x0008 or reset. Status bit 2 is high while the plaintext FIFO is full.
- R8: The engine delivers ciphertext on a cycle with `eng_out_valid` and `eng_out_ready` both high. `eng_out_ready` is low while four blocks are held. Addresses 0x0D to 0x10 read the oldest held block, with 0x0D giving bits [63:48], and they read 0x0000 when none is held.
- R9: Status at 0x14 has bit 0 high when a ciphertext block is held. All its other bits are zero except bits 1 and 2 of R7, so it reads 0x0000 after reset.
- R10: Command 0x0004 discards the oldest ciphertext block and does nothing when none is held. Other command values do nothing. Writes to 0x0D to 0x10 and 0x14 are acknowledged and ignored. The command register reads 0x0000.
- R11: Driving `rst_n` low clears all registers and FIFOs at once without waiting for a clock edge. Release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low reset |
| bus_op | input | 2 | Opcode, 2'b01 starts a transfer |
| bus_rnw | input | 1 | 1 = read, 0 = write, taken in the address phase |
| bus_addr | input | 6 | Register address, taken in the address phase |
| bus_data | inout | 16 | Shared data bus |
| bus_ack | output | 1 | Data-phase acknowledge for a decoded address |
| eng_key | output | 128 | Assembled key words |
| eng_key_load | output | 1 | One-cycle key take-up strobe |
| eng_in_valid | output | 1 | A plaintext block is offered |
| eng_in_ready | input | 1 | Engine accepts the offered plaintext block |
| eng_in_data | output | 64 | Oldest queued plaintext block |
| eng_out_valid | input | 1 | Engine offers a ciphertext block |
| eng_out_ready | output | 1 | Room for a ciphertext block |
| eng_out_data | input | 64 | Ciphertext block from the engine |

## Verification
The hardest states to reach are the FIFO edges. These are a fifth plaintext push against a full queue that the engine refuses to drain, and a ciphertext pop command issued against an empty queue. The stimulus holds `eng_in_ready` low while five blocks are staged and pushed, then releases it and follows the drain order block by block. On the output side it fills four blocks until `eng_out_ready` drops, pops them all, pops once more on empty, and shows that a fresh block still reads back whole. That last step proves the pointers survived the empty pop.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 16;

  localparam logic [1:0] OP_XFER = 2'b01;

  localparam logic [ADDR_W-1:0] A_KEY0 = 6'h01;
  localparam logic [ADDR_W-1:0] A_PT0  = 6'h09;
  localparam logic [ADDR_W-1:0] A_CT0  = 6'h0D;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h14;
  localparam logic [ADDR_W-1:0] A_CMD  = 6'h15;
  localparam logic [ADDR_W-1:0] A_ID   = 6'h16;

  localparam logic [DATA_W-1:0] CMD_KEY_LOAD = 16'h0001;
  localparam logic [DATA_W-1:0] CMD_PT_PUSH  = 16'h0002;
  localparam logic [DATA_W-1:0] CMD_CT_POP   = 16'h0004;
  localparam logic [DATA_W-1:0] CMD_OVF_CLR  = 16'h0008;

  typedef enum logic [2:0] {
    RG_NONE, RG_KEY, RG_PT, RG_CT, RG_STAT, RG_CMD, RG_ID
  } region_e;
endpackage

// File: rtl/cbs_reset_sync.sv
module cbs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_s_n = out_q;
endmodule

// File: rtl/cbs_bus_phase.sv
module cbs_bus_phase
  import cbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  output logic              data_phase,
  output logic              rnw_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic              start;
  logic              dph_d;
  logic              rnw_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    start  = (op == OP_XFER) && !data_phase;
    dph_d  = start;
    rnw_d  = start ? rnw  : rnw_q;
    addr_d = start ? addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_phase <= 1'b0;
      rnw_q      <= 1'b0;
      addr_q     <= '0;
    end else begin
      data_phase <= dph_d;
      rnw_q      <= rnw_d;
      addr_q     <= addr_d;
    end
  end
endmodule

// File: rtl/cbs_decode.sv
module cbs_decode
  import cbs_pkg::*;
#(
  parameter int unsigned KEY_WORDS = 8,
  parameter int unsigned BLK_WORDS = 4,
  parameter int unsigned KIW       = $clog2(KEY_WORDS),
  parameter int unsigned BIW       = $clog2(BLK_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [KIW-1:0]    key_idx,
  output logic [BIW-1:0]    blk_idx
);
  logic [ADDR_W-1:0] kdiff;
  logic [ADDR_W-1:0] bdiff;

  always_comb begin
    region = RG_NONE;
    kdiff  = '0;
    bdiff  = '0;
    if (addr >= A_KEY0 && addr < A_KEY0 + ADDR_W'(KEY_WORDS)) begin
      region = RG_KEY;
      kdiff  = addr - A_KEY0;
    end else if (addr >= A_PT0 && addr < A_PT0 + ADDR_W'(BLK_WORDS)) begin
      region = RG_PT;
      bdiff  = addr - A_PT0;
    end else if (addr >= A_CT0 && addr < A_CT0 + ADDR_W'(BLK_WORDS)) begin
      region = RG_CT;
      bdiff  = addr - A_CT0;
    end else if (addr == A_STAT) begin
      region = RG_STAT;
    end else if (addr == A_CMD) begin
      region = RG_CMD;
    end else if (addr == A_ID) begin
      region = RG_ID;
    end
    key_idx = KIW'(kdiff);
    blk_idx = BIW'(bdiff);
  end
endmodule

// File: rtl/cbs_fifo.sv
module cbs_fifo #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, wr_ptr_d;
  logic [PW-1:0]    rd_ptr, rd_ptr_d;
  logic [CW-1:0]    count, count_d;
  logic             do_push, do_pop;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_comb begin
    do_push  = push && !full;
    do_pop   = pop && !empty;
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (do_push) wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    unique case ({do_push, do_pop})
      2'b10:   count_d = count + 1'b1;
      2'b01:   count_d = count - 1'b1;
      default: count_d = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/cipher_bus_slave.sv
module cipher_bus_slave
  import cbs_pkg::*;
#(
  parameter int unsigned KEY_WORDS  = 8,
  parameter int unsigned BLK_WORDS  = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter logic [15:0] ID_RESET   = 16'h0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                bus_op,
  input  logic                      bus_rnw,
  input  logic [5:0]                bus_addr,
  inout  wire  [15:0]               bus_data,
  output logic                      bus_ack,
  output logic [KEY_WORDS*16-1:0]   eng_key,
  output logic                      eng_key_load,
  output logic                      eng_in_valid,
  input  logic                      eng_in_ready,
  output logic [BLK_WORDS*16-1:0]   eng_in_data,
  input  logic                      eng_out_valid,
  output logic                      eng_out_ready,
  input  logic [BLK_WORDS*16-1:0]   eng_out_data
);
  localparam int unsigned KEY_W = KEY_WORDS * DATA_W;
  localparam int unsigned BLK_W = BLK_WORDS * DATA_W;
  localparam int unsigned KIW   = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam int unsigned BIW   = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;

  logic              rst_s_n;
  logic              dph, rnw_q;
  logic [ADDR_W-1:0] addr_q;
  region_e           region;
  logic [KIW-1:0]    key_idx;
  logic [BIW-1:0]    blk_idx;

  logic [DATA_W-1:0] key_q   [KEY_WORDS];
  logic [DATA_W-1:0] key_d   [KEY_WORDS];
  logic [DATA_W-1:0] stage_q [BLK_WORDS];
  logic [DATA_W-1:0] stage_d [BLK_WORDS];
  logic [DATA_W-1:0] ct_word [BLK_WORDS];
  logic [DATA_W-1:0] id_q, id_d;
  logic              pt_ovf_q, pt_ovf_d;
  logic              key_load_d;

  logic [BLK_W-1:0]  stage_blk;
  logic [BLK_W-1:0]  ct_head;
  logic              pt_full, pt_empty, ct_full, ct_empty;
  logic              wr_en, cmd_we, data_oe;
  logic              pt_push, ct_pop, ovf_clr;
  logic [DATA_W-1:0] wdata, rd_val;

  cbs_reset_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  cbs_bus_phase u_phase (
    .clk(clk), .rst_n(rst_s_n), .op(bus_op), .rnw(bus_rnw), .addr(bus_addr),
    .data_phase(dph), .rnw_q(rnw_q), .addr_q(addr_q)
  );

  cbs_decode #(.KEY_WORDS(KEY_WORDS), .BLK_WORDS(BLK_WORDS), .KIW(KIW), .BIW(BIW)) u_dec (
    .addr(addr_q), .region(region), .key_idx(key_idx), .blk_idx(blk_idx)
  );

  // Bus handshake and command strobes
  assign wdata   = bus_data;
  assign bus_ack = dph && (region != RG_NONE);
  assign data_oe = dph && rnw_q;
  assign wr_en   = dph && !rnw_q;
  assign cmd_we  = wr_en && (region == RG_CMD);
  assign pt_push = cmd_we && (wdata == CMD_PT_PUSH);
  assign ct_pop  = cmd_we && (wdata == CMD_CT_POP);
  assign ovf_clr = cmd_we && (wdata == CMD_OVF_CLR);
  assign bus_data = data_oe ? rd_val : 'z;

  // Word packing, first address in the most significant word
  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    assign eng_key[KEY_W-1-DATA_W*i -: DATA_W] = key_q[i];
  end
  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_blk
    assign stage_blk[BLK_W-1-DATA_W*i -: DATA_W] = stage_q[i];
    assign ct_word[i] = ct_head[BLK_W-1-DATA_W*i -: DATA_W];
  end

  cbs_fifo #(.WIDTH(BLK_W), .DEPTH(FIFO_DEPTH)) u_pt_fifo (
    .clk(clk), .rst_n(rst_s_n), .push(pt_push), .push_data(stage_blk),
    .pop(eng_in_ready), .head(eng_in_data), .empty(pt_empty), .full(pt_full)
  );
  assign eng_in_valid = !pt_empty;

  cbs_fifo #(.WIDTH(BLK_W), .DEPTH(FIFO_DEPTH)) u_ct_fifo (
    .clk(clk), .rst_n(rst_s_n), .push(eng_out_valid), .push_data(eng_out_data),
    .pop(ct_pop), .head(ct_head), .empty(ct_empty), .full(ct_full)
  );
  assign eng_out_ready = !ct_full;

  // Next-state logic for the register file
  always_comb begin
    key_d      = key_q;
    stage_d    = stage_q;
    id_d       = id_q;
    key_load_d = cmd_we && (wdata == CMD_KEY_LOAD);
    pt_ovf_d   = ovf_clr ? 1'b0 : (pt_ovf_q || (pt_push && pt_full));
    if (wr_en) begin
      unique case (region)
        RG_KEY:  key_d[key_idx]   = wdata;
        RG_PT:   stage_d[blk_idx] = wdata;
        RG_ID:   id_d             = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      for (int i = 0; i < KEY_WORDS; i++) key_q[i] <= '0;
      for (int i = 0; i < BLK_WORDS; i++) stage_q[i] <= '0;
      id_q         <= ID_RESET;
      pt_ovf_q     <= 1'b0;
      eng_key_load <= 1'b0;
    end else begin
      key_q        <= key_d;
      stage_q      <= stage_d;
      id_q         <= id_d;
      pt_ovf_q     <= pt_ovf_d;
      eng_key_load <= key_load_d;
    end
  end

  // Read mux
  always_comb begin
    unique case (region)
      RG_KEY:  rd_val = key_q[key_idx];
      RG_PT:   rd_val = stage_q[blk_idx];
      RG_CT:   rd_val = ct_empty ? '0 : ct_word[blk_idx];
      RG_STAT: rd_val = {13'b0, pt_full, pt_ovf_q, !ct_empty};
      RG_ID:   rd_val = id_q;
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker
  import cbs_pkg::*;
#(
  parameter int unsigned BLK_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_op,
  input logic             bus_rnw,
  input logic             bus_ack,
  input logic             data_oe,
  input logic             eng_key_load,
  input logic             eng_in_valid,
  input logic             eng_in_ready,
  input logic [BLK_W-1:0] eng_in_data,
  input logic             pt_push,
  input logic             pt_full,
  input logic             pt_ovf
);
  p_ack_after_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_op == OP_XFER));

  p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  p_drive_read_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(bus_op == OP_XFER && bus_rnw));

  p_keyload_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_key_load |=> !eng_key_load);

  p_hold_while_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_in_valid && !eng_in_ready) |=> (eng_in_valid && $stable(eng_in_data)));

  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pt_ovf) |-> $past(pt_push && pt_full));
endmodule

bind cipher_bus_slave cbs_checker #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .bus_op(bus_op), .bus_rnw(bus_rnw),
  .bus_ack(bus_ack), .data_oe(data_oe), .eng_key_load(eng_key_load),
  .eng_in_valid(eng_in_valid), .eng_in_ready(eng_in_ready),
  .eng_in_data(eng_in_data), .pt_push(pt_push), .pt_full(pt_full),
  .pt_ovf(pt_ovf_q)
);

// File: tb/tb_cipher_bus_slave.sv
module tb_cipher_bus_slave;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_op = 2'b00;
  logic         bus_rnw = 1'b0;
  logic [5:0]   bus_addr = '0;
  wire  [15:0]  bus_data;
  logic         bus_ack;
  logic [127:0] eng_key;
  logic         eng_key_load;
  logic         eng_in_valid;
  logic         eng_in_ready = 1'b0;
  logic [63:0]  eng_in_data;
  logic         eng_out_valid = 1'b0;
  logic         eng_out_ready;
  logic [63:0]  eng_out_data = '0;
  logic         tb_drv = 1'b0;
  logic [15:0]  tb_wd = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  assign bus_data = tb_drv ? tb_wd : 'z;
  always #(CLK_P/2) clk = ~clk;

  cipher_bus_slave dut (
    .clk(clk), .rst_n(rst_n), .bus_op(bus_op), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_ack(bus_ack),
    .eng_key(eng_key), .eng_key_load(eng_key_load),
    .eng_in_valid(eng_in_valid), .eng_in_ready(eng_in_ready),
    .eng_in_data(eng_in_data), .eng_out_valid(eng_out_valid),
    .eng_out_ready(eng_out_ready), .eng_out_data(eng_out_data)
  );

  typedef struct packed {
    logic        rnw;
    logic [5:0]  addr;
    logic [15:0] wd;
    logic [15:0] exp;
    logic        ack;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h16, 16'h0000, 16'h0000, 1'b1, 4'd3},  // R3 reset value
    '{1'b0, 6'h16, 16'hA5C3, 16'h0000, 1'b1, 4'd3},  // R3 write
    '{1'b1, 6'h16, 16'h0000, 16'hA5C3, 1'b1, 4'd3},  // R3 read back
    '{1'b0, 6'h01, 16'h0123, 16'h0000, 1'b1, 4'd4},  // R4
    '{1'b0, 6'h08, 16'hFEDC, 16'h0000, 1'b1, 4'd4},  // R4
    '{1'b1, 6'h01, 16'h0000, 16'h0123, 1'b1, 4'd4},  // R4
    '{1'b1, 6'h08, 16'h0000, 16'hFEDC, 1'b1, 4'd4},  // R4
    '{1'b1, 6'h05, 16'h0000, 16'h0000, 1'b1, 4'd4},  // R4 untouched word
    '{1'b1, 6'h3F, 16'h0000, 16'h0000, 1'b0, 4'd2},  // R2 unmapped read
    '{1'b0, 6'h20, 16'h1234, 16'h0000, 1'b0, 4'd2},  // R2 unmapped write
    '{1'b1, 6'h00, 16'h0000, 16'h0000, 1'b0, 4'd2},  // R2
    '{1'b1, 6'h14, 16'h0000, 16'h0000, 1'b1, 4'd9},  // R9 idle status
    '{1'b1, 6'h0D, 16'h0000, 16'h0000, 1'b1, 4'd8},  // R8 empty window
    '{1'b0, 6'h0E, 16'hFFFF, 16'h0000, 1'b1, 4'd10}, // R10 read-only write
    '{1'b1, 6'h0E, 16'h0000, 16'h0000, 1'b1, 4'd10}, // R10
    '{1'b1, 6'h15, 16'h0000, 16'h0000, 1'b1, 4'd10}  // R10 command reads zero
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rnw, input logic [5:0] a, input logic [15:0] wd,
                      output logic [15:0] rd, output logic ack);
    @(negedge clk);
    bus_op = 2'b01; bus_rnw = rnw; bus_addr = a;
    @(negedge clk);
    bus_op = 2'b00;
    if (!rnw) begin tb_drv = 1'b1; tb_wd = wd; end
    #(CLK_P/4);
    rd = bus_data; ack = bus_ack;
    @(negedge clk);
    tb_drv = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    logic [15:0] r; logic k;
    xfer(1'b0, a, d, r, k);
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] r; logic k;
    xfer(1'b1, a, 16'h0, r, k);
    check({req, " read"}, 128'(r), 128'(exp));
    check({req, " ack"}, 128'(k), 128'(1'b1));
  endtask

  function automatic logic [63:0] pt_blk(input int b);
    return {16'h1100 + 16'(b), 16'h2200 + 16'(b), 16'h3300 + 16'(b), 16'h4400 + 16'(b)};
  endfunction

  function automatic logic [63:0] ct_blk(input int b);
    return {16'hC100 + 16'(b), 16'hC200 + 16'(b), 16'hC300 + 16'(b), 16'hC400 + 16'(b)};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] r; logic k;
    // Reset state (R11)
    #(CLK_P*2 + 3);
    check("R11 ack in reset", 128'(bus_ack), 128'(0));
    check("R11 in_valid in reset", 128'(eng_in_valid), 128'(0));
    check("R11 out_ready in reset", 128'(eng_out_ready), 128'(1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].rnw, VECS[i].addr, VECS[i].wd, r, k);
      check($sformatf("R%0d vec %0d ack", VECS[i].req, i), 128'(k), 128'(VECS[i].ack));
      if (VECS[i].rnw)
        check($sformatf("R%0d vec %0d data", VECS[i].req, i), 128'(r), 128'(VECS[i].exp));
    end
    check("R4 eng_key", eng_key, {16'h0123, 96'h0, 16'hFEDC});

    // R1: opcode held into the data phase is ignored
    @(negedge clk);
    bus_op = 2'b01; bus_rnw = 1'b1; bus_addr = 6'h16;
    @(negedge clk);
    bus_addr = 6'h3F;
    #(CLK_P/4);
    check("R1 ack in data phase", 128'(bus_ack), 128'(1));
    check("R1 data in data phase", 128'(bus_data), 128'(16'hA5C3));
    @(negedge clk);
    bus_op = 2'b00;
    #(CLK_P/4);
    check("R1 no ack after held opcode", 128'(bus_ack), 128'(0));
    @(negedge clk);

    // R5: key load strobe
    wr(6'h15, 16'h0001);
    check("R5 strobe high", 128'(eng_key_load), 128'(1));
    @(negedge clk);
    check("R5 strobe one cycle", 128'(eng_key_load), 128'(0));

    // R6/R7: fill plaintext FIFO with the engine stalled
    for (int b = 0; b < 5; b++) begin
      for (int w = 0; w < 4; w++) wr(6'h09 + 6'(w), pt_blk(b)[63-16*w -: 16]);
      if (b == 0) rd_chk("R6 staging readback", 6'h0A, pt_blk(0)[47:32]);
      wr(6'h15, 16'h0002);
      if (b == 3) rd_chk("R7 full flag", 6'h14, 16'h0004);
    end
    rd_chk("R7 overflow latched", 6'h14, 16'h0006);
    check("R6 valid", 128'(eng_in_valid), 128'(1));
    check("R6 head", 128'(eng_in_data), 128'(pt_blk(0)));
    repeat (2) @(negedge clk);
    check("R6 head held while stalled", 128'(eng_in_data), 128'(pt_blk(0)));
    eng_in_ready = 1'b1;
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      check($sformatf("R6 drain order %0d", i), 128'(eng_in_data), 128'(pt_blk(i)));
    end
    @(negedge clk);
    check("R6 drained", 128'(eng_in_valid), 128'(0));
    eng_in_ready = 1'b0;
    rd_chk("R7 overflow sticky", 6'h14, 16'h0002);
    wr(6'h15, 16'h0008);
    rd_chk("R7 overflow cleared", 6'h14, 16'h0000);

    // R10: unknown command has no effect
    wr(6'h15, 16'h0003);
    check("R10 no strobe", 128'(eng_key_load), 128'(0));
    check("R10 no push", 128'(eng_in_valid), 128'(0));
    rd_chk("R10 status unchanged", 6'h14, 16'h0000);

    // R8/R9: ciphertext FIFO
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      eng_out_valid = 1'b1; eng_out_data = ct_blk(c);
      #(CLK_P/4);
      check($sformatf("R8 ready at fill %0d", c), 128'(eng_out_ready), 128'(c < 4));
    end
    @(negedge clk);
    eng_out_valid = 1'b0;
    rd_chk("R9 block waiting", 6'h14, 16'h0001);
    for (int w = 0; w < 4; w++)
      rd_chk("R8 head word", 6'h0D + 6'(w), ct_blk(0)[63-16*w -: 16]);
    wr(6'h14, 16'hFFFF);
    rd_chk("R10 status write ignored", 6'h14, 16'h0001);
    wr(6'h15, 16'h0004);
    rd_chk("R10 pop advances", 6'h0D, ct_blk(1)[63:48]);
    for (int i = 0; i < 3; i++) wr(6'h15, 16'h0004);
    rd_chk("R9 empty status", 6'h14, 16'h0000);
    rd_chk("R8 empty window", 6'h0D, 16'h0000);
    wr(6'h15, 16'h0004);
    rd_chk("R10 pop on empty", 6'h14, 16'h0000);
    @(negedge clk);
    eng_out_valid = 1'b1; eng_out_data = ct_blk(9);
    @(negedge clk);
    eng_out_valid = 1'b0;
    rd_chk("R10 fresh block hi", 6'h0D, ct_blk(9)[63:48]);
    rd_chk("R10 fresh block lo", 6'h10, ct_blk(9)[15:0]);

    // R11: asynchronous reset mid-run
    wr(6'h09, 16'hBEEF);
    wr(6'h15, 16'h0002);
    check("R11 precondition", 128'(eng_in_valid), 128'(1));
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check("R11 fifo cleared at once", 128'(eng_in_valid), 128'(0));
    check("R11 key cleared at once", eng_key, 128'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R11 id after reset", 6'h16, 16'h0000);
    rd_chk("R11 status after reset", 6'h14, 16'h0000);
    rd_chk("R11 stage after reset", 6'h09, 16'h0000);

    summary();
  end
endmodule